// File: doc/BRIEF.md
# Global-History Correlating Branch Predictor

This block predicts the direction of conditional branches for a two-thread fetch front end. It holds a table of 2-bit saturating counters and one shift register of recent resolved outcomes per hardware thread. On each lookup, the low bits of the branch PC are XORed with the requesting thread's history, and the result selects a counter. The upper bit of that counter is the prediction, so the same branch can be steered to different counters depending on what came before it. This lets the predictor learn patterns such as strict alternation.

A static mode input sets how the two threads use the table. In shared mode, either thread may reach every entry. In partitioned mode, the thread id becomes the top index bit, so each thread is confined to its own half. The fetch side presents a lookup (PC, thread id, valid) and receives a registered prediction one cycle later. While the front-end stall input is high, lookups are not accepted and the prediction register is not clocked. The back end reports resolved outcomes through a separate update port, which is never gated.

Top module: `corr_bpred`

## Requirements
- R1: An update for thread t shifts its outcome into bit 0 of thread t's history register (taken = 1, not taken = 0). The older bits move up one place, and the oldest bit is dropped.
- R2: In shared mode (part_mode_i = 0), the counter index is pc[ALIGN+IDX_W-1:ALIGN] XOR the thread's history, zero-extended to IDX_W bits. The same formula is used for lookups and for updates.
- R3: In partitioned mode (part_mode_i = 1), index bit IDX_W-1 equals the thread id. The lower IDX_W-1 bits are pc[ALIGN+IDX_W-2:ALIGN] XOR the zero-extended history.
- R4: An update moves the selected counter one step: taken increments it, saturating at 3, and not taken decrements it, saturating at 0.
- R5: An accepted lookup raises pred_valid_o on the next clock edge. At the same edge, pred_taken_o takes bit 1 of the selected counter.
- R6: A lookup presented while stall_i is high is not accepted. pred_valid_o is low after that edge, and pred_taken_o keeps its value.
- R7: An update presented while stall_i is high is still applied to the counters and to the history.
- R8: After reset, every counter holds 01 (weakly not taken), both history registers hold zero, and pred_valid_o is low.
- R9: Updates tagged with one thread never change the other thread's history register.
- R10: A lookup and an update in the same cycle that select the same entry return the counter value from before the update.
- R11: A branch that strictly alternates taken and not taken is predicted correctly on every occurrence once the history has warmed up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| part_mode_i | input | 1 | 0 = shared table, 1 = per-thread halves |
| stall_i | input | 1 | Front-end stall; blocks lookups and gates the prediction register |
| lk_valid_i | input | 1 | Lookup request |
| lk_pc_i | input | PC_W | Lookup branch PC |
| lk_tid_i | input | 1 | Lookup thread id |
| pred_valid_o | output | 1 | Prediction valid, one cycle after an accepted lookup |
| pred_taken_o | output | 1 | Predicted direction (1 = taken) |
| up_valid_i | input | 1 | Resolved-branch update |
| up_pc_i | input | PC_W | Update branch PC |
| up_tid_i | input | 1 | Update thread id |
| up_taken_i | input | 1 | Resolved outcome (1 = taken) |

## Verification
The prediction path is exercised with several input patterns, each aimed at a different part of the design:
- A single taken update followed by lookups at XOR-shifted PCs shows whether the history enters the index.
- The same PC looked up by the other thread, in each mode, separates shared indexing from partitioned indexing and reveals any history leaking between threads.
- Long runs of one outcome steered onto a single entry expose wrong saturation at either end.
- A strictly alternating branch, which defeats a history-free counter, shows whether the correlation is actually learned.
- Stalled lookups, updates applied under stall, and a lookup colliding with an update in the same cycle distinguish the gating and the read-before-write ordering.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_RESET = 2'b01;
  localparam ctr_t CTR_MAX   = 2'b11;
  localparam ctr_t CTR_MIN   = 2'b00;

  // One saturating step of a 2-bit confidence counter
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    nxt = cur;
    if (taken) begin
      if (cur != CTR_MAX) nxt = cur + 2'b01;
    end else begin
      if (cur != CTR_MIN) nxt = cur - 2'b01;
    end
    return nxt;
  endfunction

endpackage

// File: rtl/bp_history.sv
module bp_history #(
  parameter int H = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_en,
  input  logic         upd_taken,
  output logic [H-1:0] hist_o
);

  logic [H-1:0] hist_q;
  logic [H-1:0] hist_d;
  logic [H-1:0] shifted;

  generate
    if (H == 1) begin : g_one
      assign shifted = upd_taken;
    end else begin : g_many
      assign shifted = {hist_q[H-2:0], upd_taken};
    end
  endgenerate

  always_comb begin
    hist_d = hist_q;
    if (upd_en) hist_d = shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else if (upd_en) begin
      hist_q <= hist_d;
    end
  end

  assign hist_o = hist_q;

  AST_HIST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> hist_o[0] == $past(upd_taken)); // R1

  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(hist_o)); // R9

endmodule

// File: rtl/bp_index.sv
module bp_index #(
  parameter int PC_W  = 32,
  parameter int ALIGN = 2,
  parameter int IDX_W = 6,
  parameter int H     = 4
) (
  input  logic [PC_W-1:0]  pc,
  input  logic             tid,
  input  logic [H-1:0]     hist,
  input  logic             part_mode,
  output logic [IDX_W-1:0] idx
);

  logic [IDX_W-1:0] pc_bits;
  logic [IDX_W-1:0] hist_ext;
  logic [IDX_W-1:0] hashed;
  logic             unused_pc;

  assign pc_bits   = pc[ALIGN +: IDX_W];
  assign hist_ext  = {{(IDX_W-H){1'b0}}, hist};
  assign hashed    = pc_bits ^ hist_ext;
  assign unused_pc = ^{pc[PC_W-1:ALIGN+IDX_W], pc[ALIGN-1:0]};

  always_comb begin
    if (part_mode) begin
      idx = {tid, hashed[IDX_W-2:0]};
    end else begin
      idx = hashed;
    end
  end

endmodule

// File: rtl/bp_counter_table.sv
module bp_counter_table
  import bp_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr_o,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  localparam int DEPTH = 1 << IDX_W;

  ctr_t tbl_q [DEPTH];
  ctr_t tbl_d [DEPTH];

  always_comb begin
    tbl_d = tbl_q;
    if (wr_en) tbl_d[wr_idx] = ctr_step(tbl_q[wr_idx], wr_taken);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl_q[i] <= CTR_RESET;
    end else if (wr_en) begin
      tbl_q <= tbl_d;
    end
  end

  assign rd_ctr_o = tbl_q[rd_idx];

  AST_CTR_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && tbl_q[wr_idx] == CTR_MAX) |=> tbl_q[$past(wr_idx)] == CTR_MAX); // R4

  AST_CTR_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && tbl_q[wr_idx] == CTR_MIN) |=> tbl_q[$past(wr_idx)] == CTR_MIN); // R4

  AST_CTR_UP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && tbl_q[wr_idx] != CTR_MAX)
      |=> tbl_q[$past(wr_idx)] == $past(tbl_q[wr_idx]) + 2'b01); // R4

endmodule

// File: rtl/corr_bpred.sv
module corr_bpred
  import bp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int ALIGN = 2,
  parameter int IDX_W = 6,
  parameter int H     = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            part_mode_i,
  input  logic            stall_i,
  input  logic            lk_valid_i,
  input  logic [PC_W-1:0] lk_pc_i,
  input  logic            lk_tid_i,
  output logic            pred_valid_o,
  output logic            pred_taken_o,
  input  logic            up_valid_i,
  input  logic [PC_W-1:0] up_pc_i,
  input  logic            up_tid_i,
  input  logic            up_taken_i
);

  localparam int NTHR = 2;

  logic [H-1:0]     hist_w [NTHR];
  logic [IDX_W-1:0] lk_idx;
  logic [IDX_W-1:0] up_idx;
  ctr_t             lk_ctr;
  logic             lk_en;

  logic             pv_q, pv_d;
  logic             pt_q, pt_d;

  // Per-thread history registers, each shifted only by its own updates
  generate
    for (genvar t = 0; t < NTHR; t++) begin : g_thr
      logic hupd;
      assign hupd = up_valid_i && (up_tid_i == 1'(t));
      bp_history #(.H(H)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (hupd),
        .upd_taken(up_taken_i),
        .hist_o   (hist_w[t])
      );
    end
  endgenerate

  bp_index #(.PC_W(PC_W), .ALIGN(ALIGN), .IDX_W(IDX_W), .H(H)) u_lk_index (
    .pc       (lk_pc_i),
    .tid      (lk_tid_i),
    .hist     (hist_w[lk_tid_i]),
    .part_mode(part_mode_i),
    .idx      (lk_idx)
  );

  bp_index #(.PC_W(PC_W), .ALIGN(ALIGN), .IDX_W(IDX_W), .H(H)) u_up_index (
    .pc       (up_pc_i),
    .tid      (up_tid_i),
    .hist     (hist_w[up_tid_i]),
    .part_mode(part_mode_i),
    .idx      (up_idx)
  );

  bp_counter_table #(.IDX_W(IDX_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (lk_idx),
    .rd_ctr_o(lk_ctr),
    .wr_en   (up_valid_i),
    .wr_idx  (up_idx),
    .wr_taken(up_taken_i)
  );

  // Lookup side: clock enable drops while the front end is stalled
  assign lk_en = lk_valid_i && !stall_i;

  always_comb begin
    pv_d = lk_en;
    pt_d = pt_q;
    if (lk_en) pt_d = lk_ctr[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q <= 1'b0;
    end else begin
      pv_q <= pv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pt_q <= 1'b0;
    end else if (lk_en) begin
      pt_q <= pt_d;
    end
  end

  assign pred_valid_o = pv_q;
  assign pred_taken_o = pt_q;

  AST_STALL_NO_PRED: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> !pred_valid_o); // R6

  AST_STALL_HOLD_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> $stable(pred_taken_o)); // R6

  AST_PART_OWN_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    part_mode_i |-> (lk_idx[IDX_W-1] == lk_tid_i)); // R3

  AST_LOOKUP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    lk_en |=> pred_valid_o); // R5

endmodule

// File: tb/tb_corr_bpred.sv
module tb_corr_bpred;

  localparam int PC_W = 32;
  localparam int IDX_W = 6;
  localparam int H = 4;
  localparam int DEPTH = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n;
  logic part_mode_i, stall_i;
  logic lk_valid_i, lk_tid_i;
  logic [PC_W-1:0] lk_pc_i;
  logic pred_valid_o, pred_taken_o;
  logic up_valid_i, up_tid_i, up_taken_i;
  logic [PC_W-1:0] up_pc_i;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  int mdl_ctr [DEPTH];
  int mdl_hist [2];

  always #2 clk = ~clk;

  corr_bpred #(.PC_W(PC_W), .ALIGN(2), .IDX_W(IDX_W), .H(H)) dut (
    .clk(clk), .rst_n(rst_n), .part_mode_i(part_mode_i), .stall_i(stall_i),
    .lk_valid_i(lk_valid_i), .lk_pc_i(lk_pc_i), .lk_tid_i(lk_tid_i),
    .pred_valid_o(pred_valid_o), .pred_taken_o(pred_taken_o),
    .up_valid_i(up_valid_i), .up_pc_i(up_pc_i), .up_tid_i(up_tid_i),
    .up_taken_i(up_taken_i)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s got %0d exp %0d", req, got, exp);
    end
  endtask

  function automatic int m_idx(input int pc, input int tid);
    int x;
    x = ((pc >> 2) & (DEPTH - 1)) ^ mdl_hist[tid];
    if (part_mode_i) x = (tid << (IDX_W - 1)) | (x & ((DEPTH / 2) - 1));
    return x;
  endfunction

  function automatic int pc_for(input int idx, input int tid);
    return ((idx ^ mdl_hist[tid]) & (DEPTH - 1)) << 2;
  endfunction

  function automatic int m_pred(input int pc, input int tid);
    return (mdl_ctr[m_idx(pc, tid)] >> 1) & 1;
  endfunction

  function automatic void m_update(input int pc, input int tid, input int tk);
    int i;
    i = m_idx(pc, tid);
    if (tk != 0 && mdl_ctr[i] < 3) mdl_ctr[i]++;
    if (tk == 0 && mdl_ctr[i] > 0) mdl_ctr[i]--;
    mdl_hist[tid] = ((mdl_hist[tid] << 1) | (tk & 1)) & ((1 << H) - 1);
  endfunction

  task automatic do_reset(input logic part);
    @(negedge clk);
    rst_n = 1'b0; part_mode_i = part; stall_i = 1'b0;
    lk_valid_i = 1'b0; lk_pc_i = '0; lk_tid_i = 1'b0;
    up_valid_i = 1'b0; up_pc_i = '0; up_tid_i = 1'b0; up_taken_i = 1'b0;
    for (int i = 0; i < DEPTH; i++) mdl_ctr[i] = 1;
    mdl_hist[0] = 0; mdl_hist[1] = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Lookup: drive at negedge, sample at following negedge
  task automatic lookup(input int pc, input int tid, output int v, output int t);
    lk_valid_i = 1'b1; lk_pc_i = pc; lk_tid_i = tid[0];
    @(negedge clk);
    lk_valid_i = 1'b0;
    v = pred_valid_o; t = pred_taken_o;
  endtask

  task automatic update(input int pc, input int tid, input int tk);
    up_valid_i = 1'b1; up_pc_i = pc; up_tid_i = tid[0]; up_taken_i = tk[0];
    m_update(pc, tid, tk);
    @(negedge clk);
    up_valid_i = 1'b0;
  endtask

  task automatic t_reset_state;
    int v, t;
    do_reset(1'b0);
    chk("R8 pred_valid after reset", pred_valid_o, 0);
    lookup(32'h100, 0, v, t);
    chk("R8 valid on first lookup", v, 1);
    chk("R8 counters weakly not taken", t, 0);
    lookup(32'h0FC, 1, v, t);
    chk("R8 thread1 counter weakly not taken", t, 0);
  endtask

  task automatic t_shared_index;
    int v, t;
    do_reset(1'b0);
    update(32'h10, 0, 1);       // idx 4 -> 10, hist0 = 1
    lookup(32'h14, 0, v, t);    // idx 5^1 = 4
    chk("R2 history XOR selects entry", t, 1);
    chk("R5 valid after lookup", v, 1);
    lookup(32'h10, 0, v, t);    // idx 4^1 = 5
    chk("R1 history shifted in taken", t, 0);
    lookup(32'h10, 1, v, t);    // thread1 hist 0 -> idx 4, shared
    chk("R2 shared table reached by other thread", t, 1);
  endtask

  task automatic t_partitioned;
    int v, t;
    do_reset(1'b1);
    update(32'h10, 0, 1);       // idx 4 -> 10
    lookup(32'h10, 1, v, t);    // idx {1,00100} = 36
    chk("R3 thread1 uses own half", t, 0);
    lookup(32'h14, 0, v, t);    // idx 5^1 = 4
    chk("R3 thread0 sees its update", t, 1);
    update(32'h90, 1, 1);       // pc bits 36 -> idx {1, 4} = 36
    update(32'h94, 1, 1);       // bits 37 ^1 -> low 4 -> idx 36 -> 11
    lookup(32'h10 | (3 << 2), 1, v, t);  // bits 7 ^ 3 = 4 -> idx 36
    chk("R3 top bit set by thread id", t, 1);
    lookup(32'h10, 0, v, t);    // thread0 idx 4^1=5 untouched
    chk("R3 thread0 half unaffected", t, 0);
  endtask

  task automatic t_saturate;
    int v, t;
    do_reset(1'b0);
    for (int k = 0; k < 4; k++) update(pc_for(9, 0), 0, 1);
    lookup(pc_for(9, 0), 0, v, t);
    chk("R4 counter saturates taken", t, 1);
    update(pc_for(9, 0), 0, 0);   // 3 -> 2
    lookup(pc_for(9, 0), 0, v, t);
    chk("R4 one decrement from top stays taken", t, 1);
    for (int k = 0; k < 5; k++) update(pc_for(9, 0), 0, 0);
    update(pc_for(9, 0), 0, 1);   // 0 -> 1
    lookup(pc_for(9, 0), 0, v, t);
    chk("R4 saturated low then one increment", t, 0);
    update(pc_for(9, 0), 0, 1);   // 1 -> 2
    lookup(pc_for(9, 0), 0, v, t);
    chk("R4 second increment predicts taken", t, 1);
  endtask

  task automatic t_stall;
    int v, t;
    do_reset(1'b0);
    lookup(32'h20, 0, v, t);
    stall_i = 1'b1;
    lookup(32'h20, 0, v, t);
    chk("R6 no prediction under stall", v, 0);
    chk("R6 direction held under stall", t, 0);
    update(pc_for(12, 1), 1, 1);
    update(pc_for(12, 1), 1, 1);  // idx 12 -> 11 during stall
    stall_i = 1'b0;
    lookup(pc_for(12, 1), 1, v, t);
    chk("R7 updates under stall applied", t, 1);
    chk("R7 lookup resumes after stall", v, 1);
  endtask

  task automatic t_same_cycle;
    int v, t;
    do_reset(1'b0);
    lk_valid_i = 1'b1; lk_pc_i = 32'h10; lk_tid_i = 1'b0;
    update(32'h10, 0, 1);   // both select idx 4 with old hist 0
    lk_valid_i = 1'b0;
    v = pred_valid_o; t = pred_taken_o;
    chk("R10 same-cycle lookup sees old counter", t, 0);
    lookup(32'h14, 0, v, t); // idx 5^1 = 4 now 10
    chk("R10 update landed afterwards", t, 1);
  endtask

  task automatic t_thread_hist;
    int v, t;
    do_reset(1'b0);
    update(32'h10, 0, 1);   // idx 4 -> 10, hist0 = 1
    update(32'h00, 0, 1);   // idx 0^1 = 1 -> 10, hist0 = 3
    lookup(32'h10, 1, v, t); // thread1 hist 0 -> idx 4
    chk("R9 thread1 history untouched", t, 1);
    lookup(32'h10, 0, v, t); // thread0 hist 3 -> idx 7
    chk("R9 thread0 history advanced", t, m_pred(32'h10, 0));
    chk("R9 thread0 idx7 not taken", t, 0);
  endtask

  task automatic t_alternate;
    int v, t, tk;
    do_reset(1'b0);
    for (int i = 0; i < 24; i++) begin
      tk = (i % 2 == 0) ? 1 : 0;
      lookup(32'h40, 1, v, t);
      chk("R11 prediction matches counter state", t, m_pred(32'h40, 1));
      if (i >= 16) chk("R11 alternation learned", t, tk);
      update(32'h40, 1, tk);
    end
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog got 0 exp 1");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; part_mode_i = 1'b0; stall_i = 1'b0;
    lk_valid_i = 1'b0; lk_pc_i = '0; lk_tid_i = 1'b0;
    up_valid_i = 1'b0; up_pc_i = '0; up_tid_i = 1'b0; up_taken_i = 1'b0;
    t_reset_state();
    t_shared_index();
    t_partitioned();
    t_saturate();
    t_stall();
    t_same_cycle();
    t_thread_hist();
    t_alternate();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule